// File: doc/BRIEF.md
# Fault-tolerant self-test controller

This block runs a local built-in self-test on a unit and guards the rest of the chip against that unit when something goes wrong. A serial scan path loads the length of a test run. Four command lines, covered by one parity bit, start a run or issue a clear. A run seeds a pattern generator and clears a signature register. The two register blocks under test are then switched into generator and evaluator modes for the programmed number of cycles, and the final signature is compared with an expected value supplied at the input.

The controller distrusts its own inputs. A parity violation on the command lines, a command code it does not know, an illegal internal state or a signature mismatch all send it into an isolation state. In that state the unit's drive onto the shared output bus is removed, the scan path is bypassed straight from input to output, and the unit's clock enable is dropped. The controller's own state register keeps running so that it can still decode commands. Isolation is sticky. Only a clear command with correct parity releases it.

Top module: `bist_guard`

## Requirements
- R1: After reset, both block-mode outputs are 00 (normal), busOutEn=1, scanBypass=0, clkEn=1 and testPass=0.
- R2: When the controller is idle or passed, each cycle with scanEn=1 shifts scanIn into bit 0 of a 16-bit run-length register, and the other bits move up by one. scanOut shows bit 15 of that register.
- R3: Command codes are NOP=0000, START=0011 and CLEAR=1010. Parity is even over the four command lines plus cmdPar and is checked on every clock edge. An odd count moves the controller into isolation at that edge.
- R4: A command code other than NOP, START or CLEAR, sent with correct parity, also moves the controller into isolation at that edge.
- R5: START from idle or passed gives one setup cycle with both block modes at 11 (scan stage). It is followed by the run cycles with tpgMode=01 (generator) and taeMode=10 (evaluator), then one compare cycle with both modes at 00.
- R6: The generator is a 16-bit LFSR with polynomial x^16+x^14+x^13+x^11+1: next = {s[14:0], s[15]^s[13]^s[12]^s[10]}, seeded with 16'hACE1. The signature register starts at 0, and in each run cycle it becomes {m[14:0], m[15]^m[13]^m[12]^m[10]} XOR the current generator word, before the generator advances. If the signature equals expSig at the compare cycle, testPass=1 from the next cycle on.
- R7: A signature that differs from expSig at the compare cycle moves the controller into isolation.
- R8: While isolated: busOutEn=0, clkEn=0, scanBypass=1, scanOut follows scanIn without a register, both modes are 00, and testPass=0.
- R9: While isolated, START, NOP, unknown codes, a CLEAR with wrong parity and scan shifting all have no effect. The state stays isolated and the run-length register keeps its value.
- R10: A CLEAR with correct parity returns the controller to idle at the next edge, from isolation or from any point of a run, with the R1 output values.
- R11: During a run, START and scanEn have no effect on the run or on the run-length register.
- R12: A run length of N gives N run cycles, and N=0 gives one run cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanEn | input | 1 | Shift enable for the run-length scan register |
| scanIn | input | 1 | Serial scan data in |
| cmdCode | input | 4 | Command lines |
| cmdPar | input | 1 | Parity bit for the command lines (even overall) |
| expSig | input | 16 | Expected final signature |
| scanOut | output | 1 | Serial scan data out, or scanIn when bypassed |
| tpgMode | output | 2 | Mode of the generator register block |
| taeMode | output | 2 | Mode of the evaluator register block |
| busOutEn | output | 1 | Permission for the unit to drive the shared output bus |
| scanBypass | output | 1 | Scan path bypass select |
| clkEn | output | 1 | Clock enable for the unit under test |
| testPass | output | 1 | Last run ended with a matching signature |

## Verification
A command applied before edge k takes effect at edge k. Parity and unknown-code faults, clears and the start of setup therefore show on the outputs one edge after the command is applied. For a run of length N, after the START edge there is one setup cycle, then max(N,1) generator cycles, then one compare cycle, and the pass or isolation result appears max(N,1)+2 edges after START. The bench drives its inputs and samples the outputs just after falling edges. It checks the modes in each phase at exactly those cycle counts. The run-length register is read back bit by bit through scanOut to show that ignored shifts left it unchanged.

// File: rtl/bist_guard_pkg.sv
package bist_guard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_GEN   = 3'd2,
    ST_CMP   = 3'd3,
    ST_PASS  = 3'd4,
    ST_ISO   = 3'd5
  } stState;

  localparam logic [1:0] MD_NORMAL = 2'b00;
  localparam logic [1:0] MD_TPG    = 2'b01;
  localparam logic [1:0] MD_TAE    = 2'b10;
  localparam logic [1:0] MD_SCAN   = 2'b11;

  localparam logic [3:0] CMD_NOP   = 4'h0;
  localparam logic [3:0] CMD_START = 4'h3;
  localparam logic [3:0] CMD_CLEAR = 4'hA;

  localparam int SIG_W = 16;

  typedef struct packed {
    logic seedLoad;
    logic stepEn;
    logic shiftEn;
    logic bypass;
  } dpStrobe;

  function automatic logic [SIG_W-1:0] lfsrNext(input logic [SIG_W-1:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [SIG_W-1:0] misrNext(input logic [SIG_W-1:0] s,
                                                input logic [SIG_W-1:0] d);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]} ^ d;
  endfunction

endpackage

// File: rtl/bist_guard_ctrl.sv
module bist_guard_ctrl
  import bist_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] cmdCode,
  input  logic       cmdPar,
  input  logic       lastStep,
  input  logic       sigMatch,
  output dpStrobe    strobe,
  output logic [1:0] tpgMode,
  output logic [1:0] taeMode,
  output logic       busOutEn,
  output logic       scanBypass,
  output logic       clkEn,
  output logic       testPass
);

  stState cur, nxt;
  logic parOk, cmdKnown, clearReq;

  always_comb begin
    parOk    = ~^{cmdCode, cmdPar};
    cmdKnown = (cmdCode == CMD_NOP) || (cmdCode == CMD_START) || (cmdCode == CMD_CLEAR);
    clearReq = parOk && (cmdCode == CMD_CLEAR);
  end

  always_comb begin
    nxt = cur;
    if (cur == ST_ISO) begin
      if (clearReq) nxt = ST_IDLE;
    end else if (!parOk || !cmdKnown) begin
      nxt = ST_ISO;
    end else if (cmdCode == CMD_CLEAR) begin
      nxt = ST_IDLE;
    end else begin
      case (cur)
        ST_IDLE, ST_PASS: if (cmdCode == CMD_START) nxt = ST_SETUP;
        ST_SETUP:         nxt = ST_GEN;
        ST_GEN:           if (lastStep) nxt = ST_CMP;
        ST_CMP:           nxt = sigMatch ? ST_PASS : ST_ISO;
        default:          nxt = ST_ISO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur        <= ST_IDLE;
      busOutEn   <= 1'b1;
      scanBypass <= 1'b0;
      clkEn      <= 1'b1;
    end else begin
      cur        <= nxt;
      busOutEn   <= (nxt != ST_ISO);
      scanBypass <= (nxt == ST_ISO);
      clkEn      <= (nxt != ST_ISO);
    end
  end

  always_comb begin
    tpgMode  = MD_NORMAL;
    taeMode  = MD_NORMAL;
    if (cur == ST_SETUP) begin
      tpgMode = MD_SCAN;
      taeMode = MD_SCAN;
    end else if (cur == ST_GEN) begin
      tpgMode = MD_TPG;
      taeMode = MD_TAE;
    end
    testPass        = (cur == ST_PASS);
    strobe.seedLoad = (cur == ST_SETUP);
    strobe.stepEn   = (cur == ST_GEN);
    strobe.shiftEn  = (cur == ST_IDLE) || (cur == ST_PASS);
    strobe.bypass   = scanBypass;
  end

  assert_parity_isolates_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!parOk && cur != ST_ISO) |=> (!busOutEn && !clkEn));

  assert_unknown_isolates_R4: assert property (@(posedge clk) disable iff (!rstN)
    (parOk && !cmdKnown) |=> !busOutEn);

  assert_iso_outputs_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cur == ST_ISO) |-> (!busOutEn && scanBypass && !clkEn && !testPass));

  assert_iso_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cur == ST_ISO && !clearReq) |=> (cur == ST_ISO));

  assert_clear_idles_R10: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (cur == ST_IDLE && busOutEn && clkEn));

  assert_pass_on_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testPass) |-> $past(sigMatch));

endmodule

// File: rtl/bist_guard_dp.sv
module bist_guard_dp
  import bist_guard_pkg::*;
#(
  parameter int               CNT_W = 16,
  parameter logic [SIG_W-1:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe          strobe,
  input  logic             scanEn,
  input  logic             scanIn,
  input  logic [SIG_W-1:0] expSig,
  output logic             scanOut,
  output logic             lastStep,
  output logic             sigMatch
);

  logic [CNT_W-1:0] progReg, remain;
  logic [SIG_W-1:0] lfsr, misr;
  logic             doShift;

  assign doShift = strobe.shiftEn && scanEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progReg <= '0;
    end else if (doShift) begin
      progReg <= {progReg[CNT_W-2:0], scanIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr   <= SEED;
      misr   <= '0;
      remain <= '0;
    end else if (strobe.seedLoad) begin
      lfsr   <= SEED;
      misr   <= '0;
      remain <= (progReg == '0) ? CNT_W'(1) : progReg;
    end else if (strobe.stepEn) begin
      lfsr   <= lfsrNext(lfsr);
      misr   <= misrNext(misr, lfsr);
      remain <= remain - CNT_W'(1);
    end
  end

  always_comb begin
    lastStep = (remain == CNT_W'(1));
    sigMatch = (misr == expSig);
    scanOut  = strobe.bypass ? scanIn : progReg[CNT_W-1];
  end

  assert_seed_loaded_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seedLoad |=> (lfsr == SEED && misr == '0));

  assert_lfsr_live_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepEn |-> (lfsr != '0));

  assert_prog_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !doShift |=> $stable(progReg));

endmodule

// File: rtl/bist_guard.sv
module bist_guard
  import bist_guard_pkg::*;
#(
  parameter int               CNT_W = 16,
  parameter logic [SIG_W-1:0] SEED  = 16'hACE1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        scanEn,
  input  logic        scanIn,
  input  logic [3:0]  cmdCode,
  input  logic        cmdPar,
  input  logic [15:0] expSig,
  output logic        scanOut,
  output logic [1:0]  tpgMode,
  output logic [1:0]  taeMode,
  output logic        busOutEn,
  output logic        scanBypass,
  output logic        clkEn,
  output logic        testPass
);

  dpStrobe strobe;
  logic    lastStep, sigMatch;

  bist_guard_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .cmdPar(cmdPar),
    .lastStep(lastStep), .sigMatch(sigMatch), .strobe(strobe),
    .tpgMode(tpgMode), .taeMode(taeMode), .busOutEn(busOutEn),
    .scanBypass(scanBypass), .clkEn(clkEn), .testPass(testPass)
  );

  bist_guard_dp #(.CNT_W(CNT_W), .SEED(SEED)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanEn(scanEn),
    .scanIn(scanIn), .expSig(expSig), .scanOut(scanOut),
    .lastStep(lastStep), .sigMatch(sigMatch)
  );

endmodule

// File: tb/bist_guard_tb_top.sv
module bist_guard_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scanEn = 1'b0;
  logic        scanIn = 1'b0;
  logic [3:0]  cmdCode = 4'h0;
  logic        cmdPar = 1'b0;
  logic [15:0] expSig = 16'h0;
  logic        scanOut, busOutEn, scanBypass, clkEn, testPass;
  logic [1:0]  tpgMode, taeMode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bist_guard dut_i (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .scanIn(scanIn),
    .cmdCode(cmdCode), .cmdPar(cmdPar), .expSig(expSig),
    .scanOut(scanOut), .tpgMode(tpgMode), .taeMode(taeMode),
    .busOutEn(busOutEn), .scanBypass(scanBypass), .clkEn(clkEn),
    .testPass(testPass)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] genStep(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return (s << 1) | {15'd0, fb};
  endfunction

  function automatic logic [15:0] expectSig(input int cycles);
    logic [15:0] g, m;
    g = 16'hACE1;
    m = 16'h0;
    for (int i = 0; i < cycles; i++) begin
      m = genStep(m) ^ g;
      g = genStep(g);
    end
    return m;
  endfunction

  task automatic sendCmd(input logic [3:0] code, input logic par);
    cmdCode = code;
    cmdPar  = par;
    @(negedge clk);
    cmdCode = 4'h0;
    cmdPar  = 1'b0;
  endtask

  task automatic shiftProg(input logic [15:0] val);
    scanEn = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      scanIn = val[i];
      @(negedge clk);
    end
    scanEn = 1'b0;
    scanIn = 1'b0;
  endtask

  task automatic readProg(input string req, input logic [15:0] val);
    for (int i = 15; i >= 0; i--) begin
      chk({req, " scanOut bit"}, scanOut, val[i]);
      scanEn = 1'b1;
      scanIn = 1'b0;
      @(negedge clk);
    end
    scanEn = 1'b0;
  endtask

  task automatic idleOutputs(input string req);
    chk({req, " tpgMode"}, tpgMode, 2'b00);
    chk({req, " taeMode"}, taeMode, 2'b00);
    chk({req, " busOutEn"}, busOutEn, 1'b1);
    chk({req, " scanBypass"}, scanBypass, 1'b0);
    chk({req, " clkEn"}, clkEn, 1'b1);
  endtask

  task automatic isoOutputs(input string req);
    chk({req, " busOutEn"}, busOutEn, 1'b0);
    chk({req, " clkEn"}, clkEn, 1'b0);
    chk({req, " scanBypass"}, scanBypass, 1'b1);
    chk({req, " tpgMode"}, tpgMode, 2'b00);
    chk({req, " testPass"}, testPass, 1'b0);
  endtask

  task automatic testReset();
    idleOutputs("R1 reset");
    chk("R1 reset testPass", testPass, 1'b0);
  endtask

  task automatic testScan();
    shiftProg(16'hB38D);
    readProg("R2", 16'hB38D);
  endtask

  task automatic testRun(input int n, input bit good);
    int m;
    logic [15:0] sig;
    m = (n == 0) ? 1 : n;
    sig = expectSig(m);
    expSig = good ? sig : (sig ^ 16'h0001);
    shiftProg(16'(n));
    sendCmd(4'h3, 1'b0);
    chk("R5 setup tpgMode", tpgMode, 2'b11);
    chk("R5 setup taeMode", taeMode, 2'b11);
    @(negedge clk);
    chk("R5 run tpgMode", tpgMode, 2'b01);
    chk("R5 run taeMode", taeMode, 2'b10);
    repeat (m - 1) @(negedge clk);
    chk("R12 last run cycle tpgMode", tpgMode, 2'b01);
    @(negedge clk);
    chk("R5 compare tpgMode", tpgMode, 2'b00);
    chk("R5 compare testPass", testPass, 1'b0);
    chk("R5 compare busOutEn", busOutEn, 1'b1);
    @(negedge clk);
    if (good) begin
      chk("R6 match testPass", testPass, 1'b1);
      chk("R6 match busOutEn", busOutEn, 1'b1);
    end else begin
      chk("R7 mismatch busOutEn", busOutEn, 1'b0);
      chk("R7 mismatch clkEn", clkEn, 1'b0);
    end
  endtask

  task automatic testParity();
    sendCmd(4'h0, 1'b1);
    isoOutputs("R3 parity fault");
    scanIn = 1'b1;
    #1 chk("R8 bypass high", scanOut, 1'b1);
    scanIn = 1'b0;
    #1 chk("R8 bypass low", scanOut, 1'b0);
    @(negedge clk);
    sendCmd(4'hA, 1'b0);
    idleOutputs("R10 clear after parity");
  endtask

  task automatic testUnknown();
    sendCmd(4'h5, 1'b0);
    isoOutputs("R4 unknown code");
    sendCmd(4'hA, 1'b0);
    idleOutputs("R10 clear after unknown");
  endtask

  task automatic testSticky();
    testRun(7, 1'b0);
    isoOutputs("R8 after mismatch");
    sendCmd(4'h3, 1'b0);
    isoOutputs("R9 start ignored");
    sendCmd(4'hA, 1'b1);
    isoOutputs("R9 bad-parity clear ignored");
    sendCmd(4'h0, 1'b0);
    isoOutputs("R9 nop");
    sendCmd(4'h6, 1'b0);
    isoOutputs("R9 unknown while isolated");
    shiftProg(16'hFFFF);
    isoOutputs("R9 shift while isolated");
    sendCmd(4'hA, 1'b0);
    idleOutputs("R10 clear from isolation");
    chk("R10 testPass", testPass, 1'b0);
    readProg("R9 register kept", 16'd7);
  endtask

  task automatic testAbort();
    shiftProg(16'd20);
    sendCmd(4'h3, 1'b0);
    repeat (3) @(negedge clk);
    sendCmd(4'h3, 1'b0);
    chk("R11 start during run tpgMode", tpgMode, 2'b01);
    scanEn = 1'b1;
    scanIn = 1'b1;
    repeat (3) @(negedge clk);
    scanEn = 1'b0;
    scanIn = 1'b0;
    chk("R11 scan during run taeMode", taeMode, 2'b10);
    sendCmd(4'hA, 1'b0);
    idleOutputs("R10 clear aborts run");
    readProg("R11 register kept", 16'd20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testScan();
    testRun(5, 1'b1);
    testRun(0, 1'b1);
    testRun(37, 1'b1);
    testParity();
    testUnknown();
    testSticky();
    testAbort();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule